// File: doc/BRIEF.md
# I2C Master Bit Sequencer

This block is the bottom layer of an I2C master. A byte-level controller above it hands over one command at a time: generate a START, generate a STOP, send one data bit, or receive one data bit. The block splits each command into equal quarter-period phases and moves SCL and SDA through them. It reports completion with a one-cycle acknowledge, and it returns the bit it sampled from the bus. It drives each line as an open-drain pull: a high pull output pulls the wire low, and a low pull output leaves the wire to the external pull-up.

The SCL and SDA levels that come back from the pins are conditioned before any logic uses them. Each line passes through a two-flop synchronizer and then a three-sample voting filter, which takes a new sample whenever a programmable prescaler reaches zero. A registered majority value and a one-cycle delayed copy of it follow. From these conditioned levels the block finds rising SCL edges, to capture read data, and STOP conditions on the bus. It also detects lost arbitration. When arbitration is lost it lets go of both lines at once and ends the command with the loss flag set.

The quarter-period length comes from `quarterDiv`. For correct arbitration checks, it must be longer than the conditioning latency, which is about three filter sample periods plus four cycles.

Top module: `i2c_bit_engine`

## Requirements
- R1: After the asynchronous reset `rstN` is low, or after a clock edge with `syncClr` high, `sclPullLow` and `sdaPullLow` are 0, `cmdAck` and `arbLost` are 0, `rdBit` is 1, and any command in progress is dropped without an acknowledge.
- R2: `cmdOp` is encoded as 0 = START, 1 = STOP, 2 = WRITE (bit taken from `wrBit`), 3 = READ. A command is accepted on a clock edge where `cmdValid` is high and the block is idle. A `cmdValid` that arrives while a command is in progress is ignored and does not change that command's timing or line levels.
- R3: Each phase lasts `quarterDiv`+1 cycles, counted from the accepting edge. START has five phases (A to E) and every other command has four (A to D). `cmdAck` is high for exactly one cycle, beginning N*(`quarterDiv`+1) clock edges after the accepting edge, where N is the number of phases.
- R4: The line levels during START, written as SCL/SDA with 1 = released, are: A = previous SCL level/1, B = 1/1, C = 1/0, D = 1/0, E = 0/0.
- R5: The line levels during STOP are: A = 0/0, B = 1/0, C = 1/0, D = 1/1.
- R6: The line levels during WRITE, where b is the value of `wrBit` when the command was accepted, are: A = 0/b, B = 1/b, C = 1/b, D = 0/b.
- R7: During READ, SDA is released in every phase, and SCL follows 0, 1, 1, 0. `rdBit` takes the conditioned SDA level at each rising edge of the conditioned SCL and changes at no other time except reset.
- R8: A phase in which SCL is released moves on only at a quarter tick on which the conditioned SCL is high. If a slave holds SCL low, the command is extended by whole quarter periods.
- R9: Each line is synchronized, sampled into a three-deep voting register when the `filtDiv` prescaler reaches zero, and resolved by majority. With `filtDiv` >= 1, a low pulse of one cycle on SDA has no effect on arbitration or on the sequence.
- R10: In WRITE with b = 1, if the conditioned SDA is low during phase B or C, the block releases both lines, returns to idle, and raises `arbLost` together with `cmdAck` for one cycle, one edge after the mismatch is seen.
- R11: A STOP condition seen on the bus (conditioned SDA rising while the conditioned SCL is high) sets `arbLost` with `cmdAck`, and releases both lines, if a command other than STOP is in progress. A STOP seen while idle, or during the block's own STOP command, is not flagged.
- R12: When a command completes normally, the levels of its last phase are kept while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncClr | input | 1 | Synchronous clear to reset state |
| quarterDiv | input | 16 | Quarter-period length minus one, in cycles |
| filtDiv | input | 8 | Filter sample interval minus one, in cycles |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | Command code (0 START, 1 STOP, 2 WRITE, 3 READ) |
| wrBit | input | 1 | Data bit for WRITE |
| cmdAck | output | 1 | One-cycle completion pulse |
| arbLost | output | 1 | One-cycle arbitration-lost pulse, together with cmdAck |
| rdBit | output | 1 | SDA level sampled at the last SCL rising edge |
| sclIn | input | 1 | SCL level at the pin |
| sdaIn | input | 1 | SDA level at the pin |
| sclPullLow | output | 1 | Pull SCL low when 1 |
| sdaPullLow | output | 1 | Pull SDA low when 1 |

## Verification
Line levels change on the edge that enters a phase, so the bench compares them in the middle of each phase, at (`quarterDiv`+1)/2 edges past the phase start. The acknowledge is due exactly N*(`quarterDiv`+1) edges after the accepting edge, and the bench counts edges from that edge and compares the exact count. An SDA mismatch during a WRITE of 1 ends the command one edge after phase B begins, so the bench expects `quarterDiv`+2 edges. An unexpected STOP ends the command a few filter periods after the slave lets go of SDA, and for that case the bench checks only that the loss arrives within phase B. `rdBit` is read after the acknowledge, when the SCL rising edge inside the READ has already been filtered.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bitOp_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_A    = 3'd1,
    PH_B    = 3'd2,
    PH_C    = 3'd3,
    PH_D    = 3'd4,
    PH_E    = 3'd5
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // restart the quarter divider
    logic load;     // load new line levels
    logic sclRel;   // 1 = release SCL
    logic sdaRel;   // 1 = release SDA
  } ctlStrobe_t;

  // observations from datapath to control
  typedef struct packed {
    logic tick;
    logic sclClean;
    logic sdaClean;
    logic busStop;
    logic sclRelNow;
  } lineObs_t;

  // {sclRel, sdaRel} for a phase of a command
  function automatic logic [1:0] phaseLevels(bitOp_e op, phase_e ph, logic bitVal, logic sclHold);
    logic [1:0] lv;
    lv = 2'b11;
    unique case (op)
      OP_START: begin
        unique case (ph)
          PH_A:         lv = {sclHold, 1'b1};
          PH_B:         lv = 2'b11;
          PH_C, PH_D:   lv = 2'b10;
          PH_E:         lv = 2'b00;
          default:      lv = 2'b11;
        endcase
      end
      OP_STOP: begin
        unique case (ph)
          PH_A:         lv = 2'b00;
          PH_B, PH_C:   lv = 2'b10;
          default:      lv = 2'b11;
        endcase
      end
      OP_WRITE: begin
        unique case (ph)
          PH_B, PH_C:   lv = {1'b1, bitVal};
          default:      lv = {1'b0, bitVal};
        endcase
      end
      default: begin
        unique case (ph)
          PH_B, PH_C:   lv = 2'b11;
          default:      lv = 2'b01;
        endcase
      end
    endcase
    return lv;
  endfunction

  function automatic phase_e lastPhase(bitOp_e op);
    return (op == OP_START) ? PH_E : PH_D;
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTES       = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic syncClr,
  input  logic rawIn,
  input  logic sampleEn,
  output logic clean,
  output logic dly
);
  localparam int MAJ = VOTES / 2 + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [VOTES-1:0]       voteQ;

  function automatic logic majority(logic [VOTES-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < VOTES; i++) n += int'(v[i]);
    return n >= MAJ;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      voteQ <= '1;
      clean <= 1'b1;
      dly   <= 1'b1;
    end else if (syncClr) begin
      syncQ <= '1;
      voteQ <= '1;
      clean <= 1'b1;
      dly   <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      if (sampleEn) voteQ <= {voteQ[VOTES-2:0], syncQ[SYNC_STAGES-1]};
      clean <= majority(voteQ);
      dly   <= clean;
    end
  end
endmodule

// File: rtl/i2c_line_path.sv
module i2c_line_path
  import i2c_bit_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncClr,
  input  logic [DIV_W-1:0]  quarterDiv,
  input  logic [FILT_W-1:0] filtDiv,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlStrobe_t        ctl,
  output lineObs_t          obs,
  output logic              sclRise,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  output logic              rdBit
);
  localparam int NUM_LINES = 2;
  localparam int IDX_SCL   = 0;
  localparam int IDX_SDA   = 1;

  logic [NUM_LINES-1:0] rawBus, cleanBus, dlyBus;
  logic [DIV_W-1:0]     divCnt;
  logic [FILT_W-1:0]    filtCnt;
  logic                 sampleEn;
  logic                 sclRelQ, sdaRelQ, busStopQ;

  assign rawBus   = {sdaIn, sclIn};
  assign sampleEn = (filtCnt == '0);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2c_line_filter #(.SYNC_STAGES(2), .VOTES(3)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .syncClr  (syncClr),
      .rawIn    (rawBus[g]),
      .sampleEn (sampleEn),
      .clean    (cleanBus[g]),
      .dly      (dlyBus[g])
    );
  end

  // filter prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              filtCnt <= '0;
    else if (syncClr)       filtCnt <= '0;
    else if (filtCnt == '0) filtCnt <= filtDiv;
    else                    filtCnt <= filtCnt - 1'b1;
  end

  // quarter-period divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           divCnt <= '0;
    else if (syncClr)                    divCnt <= '0;
    else if (ctl.restart || divCnt == '0) divCnt <= quarterDiv;
    else                                 divCnt <= divCnt - 1'b1;
  end

  assign sclRise = cleanBus[IDX_SCL] & ~dlyBus[IDX_SCL];

  // drive levels, read capture, stop detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclRelQ  <= 1'b1;
      sdaRelQ  <= 1'b1;
      rdBit    <= 1'b1;
      busStopQ <= 1'b0;
    end else if (syncClr) begin
      sclRelQ  <= 1'b1;
      sdaRelQ  <= 1'b1;
      rdBit    <= 1'b1;
      busStopQ <= 1'b0;
    end else begin
      if (ctl.load) begin
        sclRelQ <= ctl.sclRel;
        sdaRelQ <= ctl.sdaRel;
      end
      if (sclRise) rdBit <= cleanBus[IDX_SDA];
      busStopQ <= cleanBus[IDX_SCL] & cleanBus[IDX_SDA] & ~dlyBus[IDX_SDA];
    end
  end

  assign sclPullLow    = ~sclRelQ;
  assign sdaPullLow    = ~sdaRelQ;
  assign obs.tick      = (divCnt == '0) && !ctl.restart;
  assign obs.sclClean  = cleanBus[IDX_SCL];
  assign obs.sdaClean  = cleanBus[IDX_SDA];
  assign obs.busStop   = busStopQ;
  assign obs.sclRelNow = sclRelQ;
endmodule

// File: rtl/i2c_bit_fsm.sv
module i2c_bit_fsm
  import i2c_bit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncClr,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       wrBit,
  input  lineObs_t   obs,
  output ctlStrobe_t ctl,
  output logic       cmdAck,
  output logic       arbLost,
  output phase_e     phaseMon,
  output bitOp_e     opMon
);
  phase_e phaseQ, phaseN;
  bitOp_e opQ, opN;
  logic   bitQ, bitN, ackN, lostN;
  logic   sdaMismatch, strayStop, lostNow, advOk;
  logic [1:0] lv;

  assign sdaMismatch = (opQ == OP_WRITE) && bitQ &&
                       (phaseQ == PH_B || phaseQ == PH_C) && !obs.sdaClean;
  assign strayStop   = obs.busStop && (opQ != OP_STOP);
  assign lostNow     = (phaseQ != PH_IDLE) && (sdaMismatch || strayStop);
  assign advOk       = obs.tick && (!obs.sclRelNow || obs.sclClean);

  always_comb begin
    phaseN = phaseQ;
    opN    = opQ;
    bitN   = bitQ;
    ackN   = 1'b0;
    lostN  = 1'b0;
    ctl    = '0;
    lv     = 2'b11;
    if (phaseQ == PH_IDLE) begin
      if (cmdValid) begin
        opN         = bitOp_e'(cmdOp);
        bitN        = wrBit;
        phaseN      = PH_A;
        lv          = phaseLevels(opN, PH_A, bitN, obs.sclRelNow);
        ctl.restart = 1'b1;
        ctl.load    = 1'b1;
        ctl.sclRel  = lv[1];
        ctl.sdaRel  = lv[0];
      end
    end else if (lostNow) begin
      phaseN     = PH_IDLE;
      ackN       = 1'b1;
      lostN      = 1'b1;
      ctl.load   = 1'b1;
      ctl.sclRel = 1'b1;
      ctl.sdaRel = 1'b1;
    end else if (advOk) begin
      if (phaseQ == lastPhase(opQ)) begin
        phaseN = PH_IDLE;
        ackN   = 1'b1;
      end else begin
        phaseN     = phase_e'(phaseQ + 3'd1);
        lv         = phaseLevels(opQ, phaseN, bitQ, obs.sclRelNow);
        ctl.load   = 1'b1;
        ctl.sclRel = lv[1];
        ctl.sdaRel = lv[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= PH_IDLE;
      opQ     <= OP_START;
      bitQ    <= 1'b0;
      cmdAck  <= 1'b0;
      arbLost <= 1'b0;
    end else if (syncClr) begin
      phaseQ  <= PH_IDLE;
      opQ     <= OP_START;
      bitQ    <= 1'b0;
      cmdAck  <= 1'b0;
      arbLost <= 1'b0;
    end else begin
      phaseQ  <= phaseN;
      opQ     <= opN;
      bitQ    <= bitN;
      cmdAck  <= ackN;
      arbLost <= lostN;
    end
  end

  assign phaseMon = phaseQ;
  assign opMon    = opQ;
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncClr,
  input  logic [DIV_W-1:0]  quarterDiv,
  input  logic [FILT_W-1:0] filtDiv,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic              wrBit,
  output logic              cmdAck,
  output logic              arbLost,
  output logic              rdBit,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow
);
  ctlStrobe_t ctl;
  lineObs_t   obs;
  logic       sclRiseMon;
  phase_e     fsmPhaseMon;
  bitOp_e     fsmOpMon;

  i2c_line_path #(.DIV_W(DIV_W), .FILT_W(FILT_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .syncClr    (syncClr),
    .quarterDiv (quarterDiv),
    .filtDiv    (filtDiv),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .ctl        (ctl),
    .obs        (obs),
    .sclRise    (sclRiseMon),
    .sclPullLow (sclPullLow),
    .sdaPullLow (sdaPullLow),
    .rdBit      (rdBit)
  );

  i2c_bit_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .syncClr  (syncClr),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .wrBit    (wrBit),
    .obs      (obs),
    .ctl      (ctl),
    .cmdAck   (cmdAck),
    .arbLost  (arbLost),
    .phaseMon (fsmPhaseMon),
    .opMon    (fsmOpMon)
  );
endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       syncClr,
  input logic       cmdAck,
  input logic       arbLost,
  input logic       rdBit,
  input logic       sclPullLow,
  input logic       sdaPullLow,
  input logic       sclRise,
  input logic [2:0] fsmPhase,
  input logic [1:0] fsmOp
);
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN || syncClr)
    cmdAck |=> !cmdAck); // R3

  AST_LOST_HAS_ACK: assert property (@(posedge clk) disable iff (!rstN || syncClr)
    arbLost |-> cmdAck); // R10

  AST_LOST_RELEASES: assert property (@(posedge clk) disable iff (!rstN || syncClr)
    arbLost |-> (!sclPullLow && !sdaPullLow)); // R11

  AST_READ_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rstN || syncClr)
    (fsmOp == 2'd3 && fsmPhase != 3'd0) |-> !sdaPullLow); // R7

  AST_RDBIT_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (!sclRise && !syncClr) |=> $stable(rdBit)); // R7

  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    syncClr |=> (!sclPullLow && !sdaPullLow && !cmdAck && !arbLost && rdBit)); // R1
endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .syncClr    (syncClr),
  .cmdAck     (cmdAck),
  .arbLost    (arbLost),
  .rdBit      (rdBit),
  .sclPullLow (sclPullLow),
  .sdaPullLow (sdaPullLow),
  .sclRise    (sclRiseMon),
  .fsmPhase   (fsmPhaseMon),
  .fsmOp      (fsmOpMon)
);

// File: tb/tb_i2c_bit_engine.sv
`timescale 1ns/1ps
module tb_i2c_bit_engine;
  logic        clk = 1'b0;
  logic        rstN, syncClr, cmdValid, wrBit;
  logic [1:0]  cmdOp;
  logic [15:0] quarterDiv;
  logic [7:0]  filtDiv;
  logic        cmdAck, arbLost, rdBit, sclPullLow, sdaPullLow;
  logic        slvScl, slvSda;
  logic        sclLine, sdaLine;
  int          qDiv;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  assign sclLine    = ~(sclPullLow | slvScl);
  assign sdaLine    = ~(sdaPullLow | slvSda);
  assign quarterDiv = qDiv[15:0];

  i2c_bit_engine dut (
    .clk(clk), .rstN(rstN), .syncClr(syncClr), .quarterDiv(quarterDiv), .filtDiv(filtDiv),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .wrBit(wrBit), .cmdAck(cmdAck), .arbLost(arbLost),
    .rdBit(rdBit), .sclIn(sclLine), .sdaIn(sdaLine), .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
  );

  task automatic chk(input logic ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  // expected {sclRel, sdaRel} per phase, from R4..R7
  function automatic logic [1:0] expLv(int op, int p, logic b, logic hold);
    case (op)
      0: case (p) 0: return {hold, 1'b1}; 1: return 2'b11; 2, 3: return 2'b10; default: return 2'b00; endcase
      1: case (p) 0: return 2'b00; 1, 2: return 2'b10; default: return 2'b11; endcase
      2: case (p) 0, 3: return {1'b0, b}; default: return {1'b1, b}; endcase
      default: case (p) 0, 3: return 2'b01; default: return 2'b11; endcase
    endcase
  endfunction

  function automatic int nPhases(int op);
    return (op == 0) ? 5 : 4;
  endfunction

  task automatic doCmd(input int op, input logic b, input logic lvl, input int sclK,
                       input int sdaK, input int glK, input int busyK,
                       output int k, output logic lost);
    logic hold, done, glOn, busyOn;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op[1:0]; wrBit = b;
    hold = ~sclPullLow;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    k = 0; lost = 1'b0; done = 1'b0; glOn = 1'b0; busyOn = 1'b0;
    while (!done) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (glOn)   begin slvSda = 1'b0; glOn = 1'b0; end
      if (busyOn) begin cmdValid = 1'b0; busyOn = 1'b0; end
      if (k == sclK) slvScl = 1'b0;
      if (k == sdaK) slvSda = 1'b0;
      if (k == glK)  begin slvSda = 1'b1; glOn = 1'b1; end
      if (k == busyK) begin cmdValid = 1'b1; cmdOp = 2'd1; busyOn = 1'b1; end
      if (cmdAck) begin
        done = 1'b1;
        lost = arbLost;
      end else if (lvl && (k % (qDiv + 1)) == (qDiv + 1) / 2) begin
        logic [1:0] e, a;
        e = expLv(op, k / (qDiv + 1), b, hold);
        a = {~sclPullLow, ~sdaPullLow};
        chk(a == e, $sformatf("R4/R5/R6/R7 levels op=%0d phase=%0d", op, k / (qDiv + 1)), a, e);
      end
      if (k > 4000) begin
        chk(1'b0, "R3 no acknowledge", k, 0);
        done = 1'b1;
      end
    end
  endtask

  task automatic normalCmd(input int op, input logic b, input string tag);
    int k; logic lost;
    doCmd(op, b, 1'b1, -1, -1, -1, -1, k, lost);
    chk(k == nPhases(op) * (qDiv + 1), {tag, " R3 ack timing"}, k, nPhases(op) * (qDiv + 1));
    chk(!lost, {tag, " R11 no loss"}, lost, 0);
  endtask

  task automatic readCmd(input logic slvBit, input string tag);
    slvSda = ~slvBit;
    normalCmd(3, 1'b0, tag);
    chk(rdBit == slvBit, {tag, " R7 read bit"}, rdBit, slvBit);
    slvSda = 1'b0;
  endtask

  initial begin
    #2000000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k; logic lost; logic ok;
    void'($urandom(32'h5eed_0042));
    rstN = 1'b0; syncClr = 1'b0; cmdValid = 1'b0; cmdOp = 2'd0; wrBit = 1'b0;
    slvScl = 1'b0; slvSda = 1'b0; qDiv = 15; filtDiv = 8'd1;
    repeat (3) @(negedge clk);
    chk(!sclPullLow && !sdaPullLow, "R1 reset lines released", {sclPullLow, sdaPullLow}, 0);
    chk(!cmdAck && !arbLost, "R1 reset flags", {cmdAck, arbLost}, 0);
    chk(rdBit == 1'b1, "R1 reset rdBit", rdBit, 1);
    rstN = 1'b1;
    repeat (20) @(negedge clk);

    normalCmd(0, 1'b0, "START R4");
    normalCmd(2, 1'b1, "WRITE1 R6");
    normalCmd(2, 1'b0, "WRITE0 R6");
    readCmd(1'b0, "READ0");
    readCmd(1'b1, "READ1");
    normalCmd(1, 1'b0, "STOP R5");

    // stop on the bus while idle is not flagged (R11); idle holds STOP levels (R12)
    ok = 1'b1;
    slvSda = 1'b1;
    repeat (30) begin @(negedge clk); if (cmdAck || arbLost) ok = 1'b0; end
    slvSda = 1'b0;
    repeat (30) begin @(negedge clk); if (cmdAck || arbLost || sclPullLow || sdaPullLow) ok = 1'b0; end
    chk(ok, "R11 idle bus stop ignored, R12 lines held released", ok, 1);

    // START then levels held in idle (R12)
    normalCmd(0, 1'b0, "START2");
    ok = 1'b1;
    repeat (40) begin @(negedge clk); if (!sclPullLow || !sdaPullLow) ok = 1'b0; end
    chk(ok, "R12 START end levels held", ok, 1);

    // command while busy ignored (R2)
    doCmd(2, 1'b0, 1'b1, -1, -1, -1, qDiv + 5, k, lost);
    chk(k == 4 * (qDiv + 1), "R2 busy command ignored timing", k, 4 * (qDiv + 1));
    chk(sclPullLow && sdaPullLow && !lost, "R2 busy command ignored levels",
        {sclPullLow, sdaPullLow, lost}, 3'b110);

    // one-cycle SDA glitch with SCL high (R9)
    doCmd(2, 1'b1, 1'b1, -1, -1, (qDiv + 1) + qDiv / 2, -1, k, lost);
    chk(!lost, "R9 glitch filtered, no loss", lost, 0);
    chk(k == 4 * (qDiv + 1), "R9 glitch no timing change", k, 4 * (qDiv + 1));

    // clock stretching (R8)
    slvScl = 1'b1;
    doCmd(2, 1'b0, 1'b0, 2 * (qDiv + 1) + 2, -1, -1, -1, k, lost);
    chk(k == 5 * (qDiv + 1), "R8 stretch adds one quarter", k, 5 * (qDiv + 1));
    slvScl = 1'b0;

    // SDA mismatch (R10)
    slvSda = 1'b1;
    doCmd(2, 1'b1, 1'b0, -1, -1, -1, -1, k, lost);
    chk(lost, "R10 mismatch flagged", lost, 1);
    chk(k == qDiv + 2, "R10 mismatch timing", k, qDiv + 2);
    chk(!sclPullLow && !sdaPullLow, "R10 lines released", {sclPullLow, sdaPullLow}, 0);
    slvSda = 1'b0;
    ok = 1'b1;
    repeat (30) begin @(negedge clk); if (arbLost || cmdAck) ok = 1'b0; end
    chk(ok, "R11 release after loss not flagged while idle", ok, 1);

    // unexpected stop during READ (R11)
    normalCmd(0, 1'b0, "START3");
    slvSda = 1'b1;
    doCmd(3, 1'b0, 1'b0, -1, (qDiv + 1) + qDiv / 2, -1, -1, k, lost);
    chk(lost, "R11 stray stop flagged", lost, 1);
    chk(k < 2 * (qDiv + 1), "R11 stray stop ends command in phase B", k, 2 * (qDiv + 1));
    chk(!sclPullLow && !sdaPullLow, "R11 lines released", {sclPullLow, sdaPullLow}, 0);

    // synchronous clear mid command (R1)
    normalCmd(0, 1'b0, "START4");
    @(negedge clk); cmdValid = 1'b1; cmdOp = 2'd2; wrBit = 1'b0;
    @(negedge clk); cmdValid = 1'b0;
    repeat (qDiv + 3) @(negedge clk);
    syncClr = 1'b1;
    @(negedge clk); syncClr = 1'b0;
    chk(!sclPullLow && !sdaPullLow && rdBit, "R1 sync clear state", {sclPullLow, sdaPullLow, rdBit}, 1);
    ok = 1'b1;
    repeat (5 * (qDiv + 1)) begin @(negedge clk); if (cmdAck || sclPullLow || sdaPullLow) ok = 1'b0; end
    chk(ok, "R1 dropped command no ack", ok, 1);
    normalCmd(0, 1'b0, "START after clear R1");
    normalCmd(1, 1'b0, "STOP after clear");

    // random rounds
    for (int r = 0; r < 6; r++) begin
      qDiv    = 12 + int'($urandom % 20);
      filtDiv = 8'($urandom % 3);
      repeat (10) @(negedge clk);
      normalCmd(0, 1'b0, "rand START");
      for (int i = 0; i < 2 + int'($urandom % 4); i++) begin
        logic bv;
        bv = 1'($urandom % 2);
        if ($urandom % 2) normalCmd(2, bv, "rand WRITE R6");
        else              readCmd(bv, "rand READ");
      end
      normalCmd(1, 1'b0, "rand STOP R5");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule